// File: doc/BRIEF.md
# Boot Flash SPI Host

This block is a register-mapped SPI master that sits between a simple 32-bit register bus and a single boot NOR flash device. Software sets a byte count and a byte-order choice, drops a chip-select bit, and then accesses the data register. A write to the data register shifts one to four bytes out on MOSI. A read from the data register shifts the same number of bytes in from MISO and returns them in that same bus access. The link is strictly half duplex: each data access moves bytes in one direction only.

The bus uses address, separate read and write strobes, write data, read data and a wait signal. An access completes in the cycle where its strobe is high and `busWait` is low, and the host holds the strobe and address until then. Configuration and control accesses never wait. A data write that finds the engine idle also completes at once, and the serial transfer then runs in the background. A data read stalls until all of its bytes have arrived.

Serial timing is SPI mode 0, most significant bit first. SCLK is the system clock divided by the parameter `CLK_DIV` (default 4), and it idles low. The two chip-select pins are plain register bits, so one transaction to the flash (command, address, data) can span many data-register accesses.

Top module: `nor_spi_host`

## Requirements
- R1: After reset, the setup word (offset 0x00) reads 0, the control word (offset 0x08) reads 0xC800_0000, `csN` is 2'b11, and `sclk` is low.
- R2: At offset 0x00, bit 28 (receive byte order) and bit 27 (transmit byte order) read back as written. At offset 0x08, bits 31, 30, 29:28 (byte count) and 24 (select choice) read back as written. Bit 27 at 0x08 is the ready flag. Every other bit at these offsets reads 0.
- R3: A write to offset 0x0C sends exactly 8*(code+1) bits, with count codes 00/01/10/11 meaning 1/2/3/4 bytes. Each bit goes out most significant first, is stable on MOSI across a rising SCLK edge, and uses one SCLK period of `CLK_DIV` clocks. SCLK is low between transfers.
- R4: Transmit bytes are taken left-aligned from bit 31 down. When bit 27 of 0x00 is 1, the byte in bits 31:24 goes out first, followed by the lower lanes in descending order. When it is 0, the used lanes go out in reverse order, starting with the lowest used lane.
- R5: A read of offset 0x0C receives 8*(code+1) bits and holds `busWait` high until the last bit is in. It returns left-aligned data with the unused low lanes at 0. When bit 28 of 0x00 is 1, the first received byte lands in bits 31:24. When it is 0, the first received byte lands in the lowest used lane.
- R6: MOSI stays 0 throughout a receive. MISO has no effect on the bits sent during a transmit.
- R7: The ready flag (bit 27 of 0x08) reads 0 while a transfer is in flight and 1 once it has finished.
- R8: A data access made while a transfer is in flight waits until that transfer ends, then starts its own transfer. No bits are lost or merged.
- R9: `csN[0]` follows bit 31 of 0x08 and `csN[1]` follows bit 30. They change only on control-word writes, so a chip select can stay low across several transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte offset of the register accessed |
| busRd | input | 1 | Read strobe, held until wait is low |
| busWr | input | 1 | Write strobe, held until wait is low |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid when wait is low |
| busWait | output | 1 | Access not yet complete |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| csN | output | 2 | Active-low chip selects |

## Verification
A wrong bit counter or a wrong count decode shows up at once as extra or missing SCLK pulses, and as a ready flag that rises too early or too late within the same access. A byte-order or alignment fault only shows in the data: on MOSI it appears within the first byte, and on receive it appears in the returned word of that same stalled read. Chip-select faults appear on the pins on the next clock after a transfer starts or ends. For that reason the pins are compared with the model on every clock rather than once per access.

// File: rtl/nsf_pkg.sv
package nsf_pkg;
  localparam int WORD_W  = 32;
  localparam int CFG_OFF = 'h00;
  localparam int CTL_OFF = 'h08;
  localparam int DAT_OFF = 'h0C;

  // control -> datapath strobe bundle
  typedef struct packed {
    logic              go;
    logic              isTx;
    logic [1:0]        cntCode;
    logic [WORD_W-1:0] txWord;
  } xferCmd_t;

  // Reverse the order of the (code+1) left-aligned byte lanes; unused lanes become 0.
  function automatic logic [WORD_W-1:0] flipLanes(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] code);
    logic [WORD_W-1:0] r;
    int n;
    r = '0;
    n = int'(code) + 1;
    for (int k = 0; k < 4; k++) begin
      if (k < n) r[8*(3-k) +: 8] = w[8*(4-n+k) +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/nsf_shift_dp.sv
module nsf_shift_dp
  import nsf_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferCmd_t          cmd,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0]  divCnt;
  logic [4:0]        bitCnt;
  logic [4:0]        lastBit;
  logic [1:0]        codeQ;
  logic              isTx;
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      isTx     <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      lastBit  <= '0;
      codeQ    <= '0;
      shiftReg <= '0;
    end else if (cmd.go && !busy) begin
      busy     <= 1'b1;
      isTx     <= cmd.isTx;
      divCnt   <= '0;
      bitCnt   <= '0;
      lastBit  <= {cmd.cntCode, 3'b111};
      codeQ    <= cmd.cntCode;
      shiftReg <= cmd.isTx ? cmd.txWord : '0;
    end else if (busy) begin
      // receive: capture on the rising SCLK edge
      if (!isTx && divCnt == DIV_W'(HALF - 1))
        shiftReg <= {shiftReg[WORD_W-2:0], miso};
      if (divCnt == DIV_W'(CLK_DIV - 1)) begin
        divCnt <= '0;
        if (isTx) shiftReg <= shiftReg << 1;
        if (bitCnt == lastBit) busy <= 1'b0;
        else bitCnt <= bitCnt + 5'd1;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  assign sclk   = busy && (divCnt >= DIV_W'(HALF));
  assign mosi   = busy && isTx && shiftReg[WORD_W-1];
  assign rxWord = shiftReg << {~codeQ, 3'b000};

  // R3: a transfer only ends after its last bit period
  a_r3_full_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(bitCnt) == $past(lastBit)));

  // R8: control never issues a start into a running transfer
  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmd.go |-> !busy);
endmodule

// File: rtl/nsf_reg_ctrl.sv
module nsf_reg_ctrl
  import nsf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic              busWait,
  output logic [1:0]        csN,
  output xferCmd_t          cmd,
  input  logic              dpBusy,
  input  logic [WORD_W-1:0] rxWord
);
  logic       rdBig, wrBig, cs0, cs1, csSel, rdPend;
  logic [1:0] cntCode;
  logic       isCfg, isCtl, isDat, ready, rdDone, datWrGo, datRdGo;

  assign isCfg   = busAddr == ADDR_W'(CFG_OFF);
  assign isCtl   = busAddr == ADDR_W'(CTL_OFF);
  assign isDat   = busAddr == ADDR_W'(DAT_OFF);
  assign ready   = !dpBusy && !rdPend;
  assign rdDone  = rdPend && !dpBusy;
  assign datWrGo = busWr && isDat && ready;
  assign datRdGo = busRd && isDat && ready;

  always_comb begin
    busWait = 1'b0;
    if (isDat) begin
      if (busWr)      busWait = !ready;
      else if (busRd) busWait = !rdDone;
    end
  end

  always_comb begin
    cmd.go      = datWrGo || datRdGo;
    cmd.isTx    = busWr;
    cmd.cntCode = cntCode;
    cmd.txWord  = wrBig ? busWdata : flipLanes(busWdata, cntCode);
  end

  always_comb begin
    busRdata = '0;
    if (isCfg)      busRdata = {3'b000, rdBig, wrBig, 27'd0};
    else if (isCtl) busRdata = {cs0, cs1, cntCode, ready, 2'b00, csSel, 24'd0};
    else if (isDat) busRdata = rdBig ? rxWord : flipLanes(rxWord, cntCode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBig   <= 1'b0;
      wrBig   <= 1'b0;
      cs0     <= 1'b1;
      cs1     <= 1'b1;
      csSel   <= 1'b0;
      cntCode <= 2'b00;
      rdPend  <= 1'b0;
    end else begin
      if (busWr && isCfg) begin
        rdBig <= busWdata[28];
        wrBig <= busWdata[27];
      end
      if (busWr && isCtl) begin
        cs0     <= busWdata[31];
        cs1     <= busWdata[30];
        cntCode <= busWdata[29:28];
        csSel   <= busWdata[24];
      end
      if (datRdGo)     rdPend <= 1'b1;
      else if (rdDone) rdPend <= 1'b0;
    end
  end

  assign csN = {cs1, cs0};

  // R9: chip selects move only on a control-word write
  a_r9_cs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && isCtl) |=> $stable(csN));

  // R5: a pending read always has the engine running
  a_r5_read_engine: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdPend) |-> dpBusy);
endmodule

// File: rtl/nor_spi_host.sv
module nor_spi_host
  import nsf_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busWait,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [1:0]        csN
);
  xferCmd_t          cmd;
  logic              dpBusy;
  logic [WORD_W-1:0] rxWord;

  nsf_reg_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .busWait(busWait), .csN(csN),
    .cmd(cmd), .dpBusy(dpBusy), .rxWord(rxWord)
  );

  nsf_shift_dp #(.CLK_DIV(CLK_DIV)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .miso(miso), .busy(dpBusy),
    .sclk(sclk), .mosi(mosi), .rxWord(rxWord)
  );

  // R7: a ready flag seen on the bus means the serial clock is parked
  a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(CTL_OFF) && busRdata[27]) |-> !sclk);
endmodule

// File: tb/test_nor_spi_host.sv
module test_nor_spi_host;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busWait, sclk, mosi, csN0, csN1;
  logic [1:0]  csN;
  logic        miso = 1'b0;

  int nChecks = 0, nErr = 0, cyc = 0;
  logic [1:0] expCs = 2'b11;
  bit   rxActive = 0;
  logic prevSclk = 1'b0;
  logic mosiSeen[$];
  logic misoBits[$];
  int   misoIdx = 0, lastRise = -1, risePeriod = 0;

  nor_spi_host #(.CLK_DIV(DIV), .ADDR_W(8)) i_nor_spi_host (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .busWait(busWait), .sclk(sclk),
    .mosi(mosi), .miso(miso), .csN(csN)
  );
  assign csN0 = csN[0];
  assign csN1 = csN[1];

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nErr++;
      $display("FAIL R3 watchdog actual=%0d expected<100000", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  // Flash-side model and per-clock comparison
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (sclk && !prevSclk) begin
        mosiSeen.push_back(mosi);
        if (lastRise >= 0) risePeriod = cyc - lastRise;
        lastRise = cyc;
      end
      if (!sclk && prevSclk) misoIdx++;
      miso = (misoIdx < misoBits.size()) ? misoBits[misoIdx] : 1'b0;
      chk(csN == expCs, "R9 csN per clock", {30'd0, csN}, {30'd0, expCs});
      if (rxActive) chk(mosi == 1'b0, "R6 mosi idle in receive", {31'd0, mosi}, 32'd0);
    end
    prevSclk = sclk;
  end

  task automatic busAcc(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    busAddr = a; busWr = wr; busRd = !wr; busWdata = wd;
    waits = 0;
    #1;
    while (busWait) begin
      waits++;
      @(negedge clk); #1;
    end
    rd = busRdata;
    if (wr && a == 8'h08) expCs = {wd[30], wd[31]};
    @(negedge clk);
    busWr = 0; busRd = 0;
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] d; int w;
    busAcc(1, a, wd, d, w);
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    int w;
    busAcc(0, a, 32'd0, d, w);
  endtask

  task automatic waitReady();
    logic [31:0] d;
    for (int i = 0; i < 400; i++) begin
      rdReg(8'h08, d);
      if (d[27]) break;
    end
  endtask

  task automatic setMiso(input logic [31:0] stream, input int nBits);
    misoBits.delete();
    for (int i = 0; i < nBits; i++) misoBits.push_back(stream[31-i]);
    misoIdx = 0;
    miso = misoBits[0];
  endtask

  // Bench view of the wire order: first byte at bits 31:24
  function automatic logic [31:0] wireOrder(input logic [31:0] w, input int n, input bit big);
    logic [31:0] s = '0;
    for (int k = 0; k < n; k++)
      s[31-8*k -: 8] = big ? w[31-8*k -: 8] : w[8*(4-n+k) +: 8];
    return s;
  endfunction

  function automatic logic [31:0] placeRx(input logic [31:0] s, input int n, input bit big);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) begin
      if (big) r[31-8*k -: 8] = s[31-8*k -: 8];
      else     r[8*(4-n+k) +: 8] = s[31-8*k -: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] seenWord();
    logic [31:0] v = '0;
    for (int i = 0; i < mosiSeen.size() && i < 32; i++) v[31-i] = mosiSeen[i];
    return v;
  endfunction

  task automatic txCase(input logic [31:0] w, input int n, input bit big, input string req);
    logic [31:0] exp;
    wrReg(8'h00, {3'b000, 1'b0, big, 27'd0});
    wrReg(8'h08, {1'b0, 1'b1, 2'(n-1), 28'd0});
    setMiso(32'h6B3D_A5C9, 32);   // junk on MISO must not matter (R6)
    mosiSeen.delete();
    wrReg(8'h0C, w);
    waitReady();
    exp = wireOrder(w, n, big);
    chk(mosiSeen.size() == 8*n, {req, " bit count"}, mosiSeen.size(), 8*n);
    chk(seenWord() == exp, {req, " mosi stream"}, seenWord(), exp);
  endtask

  task automatic rxCase(input logic [31:0] s, input int n, input bit big, input string req);
    logic [31:0] d, exp; int w;
    wrReg(8'h00, {3'b000, big, 1'b0, 27'd0});
    wrReg(8'h08, {1'b0, 1'b1, 2'(n-1), 28'd0});
    setMiso(s, 8*n);
    mosiSeen.delete();
    rxActive = 1;
    busAcc(0, 8'h0C, 32'd0, d, w);
    rxActive = 0;
    exp = placeRx(s, n, big);
    chk(d == exp, {req, " read data"}, d, exp);
    chk(w >= 8*n*DIV, {req, " read stalls"}, w, 8*n*DIV);
    chk(mosiSeen.size() == 8*n, {req, " rx bit count"}, mosiSeen.size(), 8*n);
  endtask

  initial begin
    logic [31:0] d;
    int w1, w2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(csN == 2'b11, "R1 csN", {30'd0, csN}, 32'd3);
    chk(sclk == 1'b0, "R1 sclk", {31'd0, sclk}, 32'd0);
    rdReg(8'h00, d); chk(d == 32'd0, "R1 setup word", d, 32'd0);
    rdReg(8'h08, d); chk(d == 32'hC800_0000, "R1 control word", d, 32'hC800_0000);

    // R2 readback and reserved bits
    wrReg(8'h00, 32'hFFFF_FFFF);
    rdReg(8'h00, d); chk(d == 32'h1800_0000, "R2 setup readback", d, 32'h1800_0000);
    wrReg(8'h08, 32'h77FF_FFFF);
    rdReg(8'h08, d); chk(d == 32'h7900_0000, "R2 control readback", d, 32'h7900_0000);
    wrReg(8'h08, 32'h4000_0000);
    rdReg(8'h08, d); chk(d == 32'h4800_0000, "R2 control cleared", d, 32'h4800_0000);

    // R3 / R4 transmit patterns
    txCase(32'hA5C3_1E70, 4, 1, "R4 big 4B");
    chk(risePeriod == DIV, "R3 sclk period", risePeriod, DIV);
    txCase(32'h5A00_0000, 1, 1, "R3 1B");
    txCase(32'h1122_3344, 4, 0, "R4 little 4B");
    txCase(32'hCAFE_9900, 3, 0, "R4 little 3B");
    txCase(32'hBEEF_0000, 2, 1, "R3 big 2B");
    chk(csN == 2'b10, "R9 cs held low after transfers", {30'd0, csN}, 32'd2);
    chk(sclk == 1'b0, "R3 sclk idle low", {31'd0, sclk}, 32'd0);

    // R5 / R6 receive patterns
    rxCase(32'hD1E2_F304, 4, 1, "R5 big 4B");
    rxCase(32'h9C00_0000, 1, 1, "R5 1B");
    rxCase(32'h1357_9B00, 3, 0, "R5 little 3B");
    rxCase(32'h8421_0000, 2, 0, "R5 little 2B");

    // R7 ready flag during and after a transfer
    wrReg(8'h00, 32'h1800_0000);
    wrReg(8'h08, 32'h4000_0000);
    mosiSeen.delete();
    wrReg(8'h0C, 32'h3C00_0000);
    rdReg(8'h08, d); chk(d[27] == 1'b0, "R7 ready low while busy", d, 32'h4000_0000);
    waitReady();
    rdReg(8'h08, d); chk(d[27] == 1'b1, "R7 ready high after", d, 32'h4800_0000);

    // R8 back-to-back data writes
    mosiSeen.delete();
    busAcc(1, 8'h0C, 32'hF000_0000, d, w1);
    busAcc(1, 8'h0C, 32'h0F00_0000, d, w2);
    chk(w1 == 0, "R8 first write no wait", w1, 0);
    chk(w2 > 0, "R8 second write waits", w2, 1);
    waitReady();
    chk(mosiSeen.size() == 16, "R8 total bits", mosiSeen.size(), 16);
    chk(seenWord() == 32'hF00F_0000, "R8 two bytes in order", seenWord(), 32'hF00F_0000);

    // R9 release
    wrReg(8'h08, 32'hC000_0000);
    @(negedge clk);
    chk(csN == 2'b11, "R9 cs release", {30'd0, csN}, 32'd3);

    $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule